// File: doc/BRIEF.md
# Parity Puncturer with Fine Rate Control

This block sits behind a systematic channel encoder and trims its output rate in small steps. Each incoming bit carries a flag that says whether it is a systematic bit or a parity bit. A frame's systematic bits come first and its parity bits follow. Every systematic bit goes through unchanged. Of the parity bits, the block keeps a programmable number out of each group of sixteen, and it spreads the kept bits evenly along the parity run. With a keep count of k and an encoder rate r, the overall rate becomes r/(r + (k/16)(1-r)). The encoder has five coarse rates and the keep count has nine legal settings, so there are 45 overall rates between 1/2 and 32/33.

Both sides of the block use a valid/ready handshake. A start-of-frame flag marks the first input bit of a frame and an end-of-frame flag marks the last one. The keep count is captured together with the first bit of each frame and holds for the whole frame. On the output side, a last marker goes on the final bit that is actually emitted. The block holds one kept bit back, so it can still set that marker when the frame's closing parity bit is dropped.

Top module: `punct_top`

## Requirements
- R1: Every systematic input bit (parity flag 0) appears on the output, in arrival order, with its data value unchanged and out_parity = 0.
- R2: Parity bits are numbered n = 0, 1, 2, ... from the first parity bit of the frame. With an effective keep count k, parity bit n is emitted (out_parity = 1, data unchanged) exactly when floor((n+1)k/16) > floor(nk/16). As a result, each aligned group of 16 parity bits yields exactly k emitted bits.
- R3: A keep_num value below 8 or above 16 acts as 16, meaning no parity bit is removed.
- R4: keep_num is sampled only on the input transfer that carries in_sof. Changes to keep_num later in the frame do not alter which bits are emitted.
- R5: The parity numbering of R2 restarts at zero in every frame. Two identical frames sent back to back therefore produce identical output.
- R6: out_last is 1 on the final bit emitted for a frame and 0 on every other bit. This holds also when the frame's last input bit is a parity bit that gets dropped. No bit of the next frame is accepted while that final bit is still waiting to leave.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_bit, out_parity and out_last hold their values.
- R8: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Input bit can be taken |
| in_bit | input | 1 | Input data bit |
| in_parity | input | 1 | 1 for a parity bit, 0 for a systematic bit |
| in_sof | input | 1 | First bit of a frame |
| in_eof | input | 1 | Last bit of a frame |
| keep_num | input | 5 | Parity bits kept per 16 (8..16 legal) |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Downstream takes the output bit |
| out_bit | output | 1 | Output data bit |
| out_parity | output | 1 | Type flag of the output bit |
| out_last | output | 1 | Final emitted bit of a frame |

## Verification
The assertions take the input to be well framed. in_sof and in_eof each appear exactly once per frame, on its first and last bits. All systematic bits come before any parity bit, so every frame emits at least one bit. The per-16 window check also assumes the input stays stable while in_valid waits for in_ready. The bench meets these conditions by building every frame in one task. That task marks the start and end flags itself, always includes at least one systematic bit, and holds each offered bit until the handshake completes. Back-pressure comes from a pseudo-random out_ready pattern.

// File: rtl/punct_pkg.sv
package punct_pkg;
  localparam int unsigned KEEP_W   = 5;
  localparam int unsigned PERIOD   = 16;
  localparam int unsigned MIN_KEEP = 8;
  localparam int unsigned PH_W     = $clog2(PERIOD);
  localparam int unsigned SUM_W    = KEEP_W + 1;

  typedef logic [KEEP_W-1:0] keep_t;
  typedef logic [PH_W-1:0]   phase_t;
  typedef logic [SUM_W-1:0]  sum_t;

  typedef struct packed {
    logic data;
    logic parity;
  } pbit_t;

  // Illegal keep counts fall back to "keep everything".
  function automatic keep_t clamp_keep(input keep_t k);
    if (k < keep_t'(MIN_KEEP) || k > keep_t'(PERIOD)) return keep_t'(PERIOD);
    return k;
  endfunction

  function automatic sum_t phase_sum(input phase_t ph, input keep_t k);
    return sum_t'(ph) + sum_t'(k);
  endfunction

  function automatic logic phase_wraps(input sum_t s);
    return s >= sum_t'(PERIOD);
  endfunction

  function automatic phase_t phase_next(input sum_t s);
    if (phase_wraps(s)) return phase_t'(s - sum_t'(PERIOD));
    return phase_t'(s);
  endfunction
endpackage

// File: rtl/punct_rate_ctrl.sv
module punct_rate_ctrl
  import punct_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  is_par,
  input  logic  sof,
  input  keep_t keep_in,
  output logic  pick
);
  phase_t phase_q;
  keep_t  keep_q;
  keep_t  eff_keep;
  phase_t base_ph;
  sum_t   sum;

  always_comb begin
    eff_keep = sof ? clamp_keep(keep_in) : keep_q;
    base_ph  = sof ? '0 : phase_q;
    sum      = phase_sum(base_ph, eff_keep);
    pick     = !is_par || phase_wraps(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      keep_q  <= keep_t'(PERIOD);
    end else if (step) begin
      if (sof) keep_q <= eff_keep;
      if (is_par)   phase_q <= phase_next(sum);
      else if (sof) phase_q <= '0;
    end
  end
endmodule

// File: rtl/punct_tail_buf.sv
module punct_tail_buf
  import punct_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  output logic  fire,
  input  logic  pick,
  input  logic  eof,
  input  pbit_t in_data,
  input  logic  out_ready,
  output logic  out_valid,
  output pbit_t out_data,
  output logic  out_last,
  output logic  hold_final
);
  pbit_t hold_q;
  logic  hold_v;
  logic  o_free;
  logic  move_h;

  always_comb begin
    o_free   = !out_valid || out_ready;
    in_ready = !hold_final && (!hold_v || o_free);
    fire     = in_valid && in_ready;
    move_h   = hold_v && (hold_final ? o_free : (fire && (pick || eof)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (move_h) begin
      out_valid <= 1'b1;
      out_data  <= hold_q;
      out_last  <= hold_final || (!pick && eof);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_v     <= 1'b0;
      hold_final <= 1'b0;
    end else if (fire && pick) begin
      hold_q     <= in_data;
      hold_v     <= 1'b1;
      hold_final <= eof;
    end else if (move_h) begin
      hold_v     <= 1'b0;
      hold_final <= 1'b0;
    end
  end
endmodule

// File: rtl/punct_top.sv
module punct_top
  import punct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              in_parity,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [KEEP_W-1:0] keep_num,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit,
  output logic              out_parity,
  output logic              out_last
);
  logic  in_fire;
  logic  pick;
  logic  hold_final;
  pbit_t in_data;
  pbit_t out_data;

  assign in_data = '{data: in_bit, parity: in_parity};

  punct_rate_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (in_fire),
    .is_par  (in_parity),
    .sof     (in_sof),
    .keep_in (keep_num),
    .pick    (pick)
  );

  punct_tail_buf buf_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .fire       (in_fire),
    .pick       (pick),
    .eof        (in_eof),
    .in_data    (in_data),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .hold_final (hold_final)
  );

  assign out_bit    = out_data.data;
  assign out_parity = out_data.parity;
endmodule

// File: rtl/punct_checker.sv
module punct_checker
  import punct_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_parity,
  input logic        in_sof,
  input logic [KEEP_W-1:0] keep_num,
  input logic        pick,
  input logic        hold_final,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_bit,
  input logic        out_parity,
  input logic        out_last
);
  logic   fire;
  keep_t  legal_k;
  phase_t w_cnt, base_cnt;
  keep_t  w_kept, base_kept, w_k, cur_k;

  assign fire      = in_valid && in_ready;
  assign legal_k   = (keep_num >= keep_t'(MIN_KEEP) && keep_num <= keep_t'(PERIOD))
                     ? keep_num : keep_t'(PERIOD);
  assign base_cnt  = in_sof ? '0 : w_cnt;
  assign base_kept = in_sof ? '0 : w_kept;
  assign cur_k     = in_sof ? legal_k : w_k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_cnt <= '0; w_kept <= '0; w_k <= keep_t'(PERIOD);
    end else if (fire) begin
      if (in_sof) w_k <= legal_k;
      if (in_parity) begin
        if (base_cnt == phase_t'(PERIOD - 1)) begin
          w_cnt <= '0; w_kept <= '0;
        end else begin
          w_cnt  <= base_cnt + 1'b1;
          w_kept <= base_kept + keep_t'(pick);
        end
      end else if (in_sof) begin
        w_cnt <= '0; w_kept <= '0;
      end
    end
  end

  assert_sys_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_parity |-> pick);

  assert_window_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_parity && base_cnt == phase_t'(PERIOD - 1)
      |-> (base_kept + keep_t'(pick)) == cur_k);

  // R3 and R5: first parity bit of a frame starts from phase zero
  assert_frame_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_sof && in_parity |-> pick == (legal_k == keep_t'(PERIOD)));

  assert_tail_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_final |-> !in_ready);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit)
      && $stable(out_parity) && $stable(out_last));

  assert_reset_idle_R8: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind punct_top punct_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_parity  (in_parity),
  .in_sof     (in_sof),
  .keep_num   (keep_num),
  .pick       (pick),
  .hold_final (hold_final),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_bit    (out_bit),
  .out_parity (out_parity),
  .out_last   (out_last)
);

// File: tb/punct_top_tb.sv
module punct_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_parity = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [4:0] keep_num = 5'd16;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, out_parity, out_last;

  int n_cmp = 0, n_bad = 0;
  logic bp_on = 1'b0;
  logic [15:0] lf_rdy = 16'hACE1;
  logic [15:0] lf_dat = 16'h1D2B;

  logic ex_bit[1024], ex_par[1024], gt_bit[1024], gt_par[1024], gt_last[1024];
  int ex_n = 0, gt_n = 0;

  always #2.5 clk = ~clk;

  punct_top dut_i (.*);

  initial begin
    forever begin
      @(negedge clk);
      lf_rdy = {lf_rdy[14:0], lf_rdy[15] ^ lf_rdy[13] ^ lf_rdy[12] ^ lf_rdy[10]};
      out_ready = bp_on ? (lf_rdy[0] | lf_rdy[3]) : 1'b1;
    end
  end

  initial begin
    forever begin
      @(negedge clk); #2;
      if (out_valid && out_ready && gt_n < 1024) begin
        gt_bit[gt_n] = out_bit; gt_par[gt_n] = out_parity; gt_last[gt_n] = out_last;
        gt_n++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit kept(input int n, input int k);
    return ((n + 1) * k) / 16 > (n * k) / 16;
  endfunction

  function automatic int legal(input int k);
    return (k < 8 || k > 16) ? 16 : k;
  endfunction

  task automatic send_bit(input logic b, input logic par, input logic sof,
                          input logic eof, input logic [4:0] k);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_parity = par; in_sof = sof; in_eof = eof; keep_num = k;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  // One frame: s systematic bits then v parity bits; keep count k at sof, k_late after.
  task automatic drive_frame(input int s, input int v, input int k, input int k_late);
    int eff = legal(k);
    for (int i = 0; i < s + v; i++) begin
      logic b;
      logic par;
      lf_dat = {lf_dat[14:0], lf_dat[15] ^ lf_dat[14] ^ lf_dat[12] ^ lf_dat[3]};
      b = lf_dat[0];
      par = (i >= s);
      if (!par || kept(i - s, eff)) begin
        ex_bit[ex_n] = b; ex_par[ex_n] = par; ex_n++;
      end
      send_bit(b, par, i == 0, i == s + v - 1, (i == 0) ? 5'(k) : 5'(k_late));
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic begin_case();
    ex_n = 0; gt_n = 0;
  endtask

  // Compare the collected stream; last marker expected at the end of each frame.
  task automatic finish_case(input string req, input int frame_ends[$]);
    int bad_data = 0, bad_last = 0;
    for (int w = 0; w < 400 && gt_n < ex_n; w++) @(negedge clk);
    repeat (20) @(negedge clk);
    check(gt_n == ex_n, {req, " count"}, gt_n, ex_n);
    for (int i = 0; i < ex_n && i < gt_n; i++) begin
      bit want_last = 1'b0;
      foreach (frame_ends[j]) if (frame_ends[j] == i) want_last = 1'b1;
      if (gt_bit[i] !== ex_bit[i] || gt_par[i] !== ex_par[i]) bad_data++;
      if (gt_last[i] !== want_last) bad_last++;
    end
    check(bad_data == 0, {req, " data/type"}, bad_data, 0);
    check(bad_last == 0, "R6 last marker", bad_last, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R8 in_ready", in_ready, 1);
  endtask

  task automatic t_full_keep();     // R1, R2 with k = 16
    begin_case(); drive_frame(12, 20, 16, 16); finish_case("R1 R2 k16", '{31});
  endtask

  task automatic t_half_keep();     // R2 with k = 8, last parity dropped (R6)
    begin_case(); drive_frame(6, 7, 8, 8); finish_case("R2 k8", '{8});
  endtask

  task automatic t_odd_keep();      // R2 with k = 11 over several windows
    int n = 10;
    for (int i = 0; i < 48; i++) n += kept(i, 11);
    begin_case(); drive_frame(10, 48, 11, 11); finish_case("R2 k11", '{n - 1});
  endtask

  task automatic t_backpressure();  // R7 with k = 13
    int n = 9;
    for (int i = 0; i < 40; i++) n += kept(i, 13);
    bp_on = 1'b1;
    begin_case(); drive_frame(9, 40, 13, 13); finish_case("R7 k13 stall", '{n - 1});
    bp_on = 1'b0;
  endtask

  task automatic t_clamp();         // R3: 5 and 20 act as 16
    begin_case(); drive_frame(4, 18, 5, 5); finish_case("R3 k5", '{21});
    begin_case(); drive_frame(4, 18, 20, 20); finish_case("R3 k20", '{21});
  endtask

  task automatic t_late_change();   // R4: mid-frame switch from 9 to 16 ignored
    int n = 5;
    for (int i = 0; i < 32; i++) n += kept(i, 9);
    begin_case(); drive_frame(5, 32, 9, 16); finish_case("R4 late keep", '{n - 1});
  endtask

  task automatic t_back_to_back();  // R5: same pattern each frame, with stalls
    int n = 3;
    for (int i = 0; i < 21; i++) n += kept(i, 12);
    bp_on = 1'b1;
    begin_case();
    drive_frame(3, 21, 12, 12);
    drive_frame(3, 21, 12, 12);
    finish_case("R5 two frames", '{n - 1, 2 * n - 1});
    bp_on = 1'b0;
  endtask

  task automatic t_sys_only();      // R1, R6: frame without parity
    begin_case(); drive_frame(7, 0, 8, 8); finish_case("R1 systematic only", '{6});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_full_keep();
    t_half_keep();
    t_odd_keep();
    t_backpressure();
    t_clamp();
    t_late_change();
    t_back_to_back();
    t_sys_only();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule